// File: doc/BRIEF.md
# Row LUT Burst Loader

This block refills the lookup tables of one row of a reconfigurable array while the processor runs. The row holds a parameterised number of cells, 16 by default. Each cell has two 4-input, 2-output lookup tables. Each table stores 32 bits and, for configuration, is seen as four 8-bit bytes. A three-bit sequencer address chooses both the table within every cell and the byte within that table. A single burst cycle takes four 32-bit words from the processor's global buses. From those words it writes one byte into every cell of the row at once. Eight such cycles cover both tables of every cell, so the contents of 32 processor registers land in one row.

A one-cycle `init` pulse rewinds the sequencer. Each cycle with `burst_on` high then writes one address and steps the sequencer. After the eighth write the sequencer raises `done` and stops accepting further burst cycles until the next `init`. Separately from the burst path, a narrow configuration port writes a single byte into a chosen cell, which treats each table as a small memory. The tables are read without interruption through per-table 4-bit indices for normal computation.

Both streams are accepted without back-pressure. A burst word set is taken in every cycle in which `burst_on` is high and the sequencer is neither finished nor being rewound. A configuration byte is taken whenever no burst write happens in the same cycle. The block never stalls the source.

Top module: `lut_burst_loader`

## Requirements
- R1: After reset the sequencer address is 0, `done` is 0, no write enable is asserted and every table reads 0 for any index.
- R2: A cycle with `init` high sets the address to 0 and clears `done` at the next edge. `init` overrides `burst_on`, so no burst write happens in that cycle.
- R3: A burst write happens in a cycle with `burst_on` high, `init` low and `done` low. In that cycle `wr_en` holds exactly one bit per cell, bit 2k+addr[2] for cell k. `wr_addr` equals addr[1:0]. The address then advances by one.
- R4: The burst byte written into cell k carries, for each word j from 0 to 3, bits [2k+1:2k] of word j. That slice sits in bits [2j+1:2j] of the byte. Word j occupies `bus_words` bits [32j+31:32j].
- R5: Table l of cell k is driven by `lut_idx` bits [8k+4l+3:8k+4l] and answers on `lut_out` bits [4k+2l+1:4k+2l]. Index i returns table bits [2i+1:2i]. Byte b of a table holds table bits [8b+7:8b], and address bit 2 selects table 0 or 1.
- R6: `done` rises at the edge that completes the eighth burst write, and the address returns to 0 at that same edge.
- R7: While `done` is high, `burst_on` has no effect: no enable is asserted, the address holds and the table contents are unchanged.
- R8: While `burst_on` is low, no burst enable is asserted and table reads return the stored contents.
- R9: When `cfg_we` is high and no burst write happens in that cycle, `cfg_data` is written into cell `cfg_cell` at address `cfg_addr`, using the same address layout as R5. A configuration write that coincides with a burst write is dropped.
- R10: A cycle with `burst_on` low in the middle of a burst holds the address and `done`. The burst resumes at the same address afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Rewinds the burst sequencer |
| burst_on | input | 1 | Requests one burst write this cycle |
| bus_words | input | 128 | Four 32-bit global bus words, word j in bits [32j+31:32j] |
| cfg_we | input | 1 | Single-byte configuration write strobe |
| cfg_cell | input | 4 | Target cell of the configuration write |
| cfg_addr | input | 3 | Target address (table select, byte) |
| cfg_data | input | 8 | Configuration byte |
| lut_idx | input | 128 | 4-bit read index per table |
| lut_out | output | 64 | 2-bit read result per table |
| wr_en | output | 32 | Burst write enable per table |
| wr_addr | output | 2 | Byte address of the burst write |
| wr_data | output | 128 | Burst byte per cell, cell k in bits [8k+7:8k] |
| burst_addr | output | 3 | Current sequencer address |
| done | output | 1 | Full row has been written |

## Verification
The bench goes after the edges of the sequence. One case is the wrap from address 7 to 0 together with the rise of `done`: a sequencer that lets the address keep counting would overwrite table 0 on a ninth burst. Another is `init` arriving in the same cycle as `burst_on`: if `init` lost priority, a stray byte would land at the old address. Pauses in the middle of a burst must hold the address, or a design would skip bytes. Configuration writes that collide with a burst must be dropped, or they would corrupt the cell that the burst touches. Every cycle, the bench compares the write outputs and all 32 table reads with a behavioural row model. Any error in slice position or byte order therefore shows up as a wrong bit at a known index.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
  // Structure of one cell: two 4:2 tables, each 32 bits seen as four bytes.
  localparam int unsigned LBW_N_WORDS   = 4;
  localparam int unsigned LBW_SLICE_W   = 2;
  localparam int unsigned LBW_BYTE_W    = LBW_N_WORDS * LBW_SLICE_W;
  localparam int unsigned LBW_N_LUTS    = 2;
  localparam int unsigned LBW_LUT_BYTES = 4;
  localparam int unsigned LBW_IDX_W     = 4;
  localparam int unsigned LBW_OUT_W     = 2;
  localparam int unsigned LBW_LUT_BITS  = LBW_LUT_BYTES * LBW_BYTE_W;
  localparam int unsigned LBW_BSEL_W    = $clog2(LBW_LUT_BYTES);
  localparam int unsigned LBW_LSEL_W    = $clog2(LBW_N_LUTS);
  localparam int unsigned LBW_ADDR_W    = LBW_BSEL_W + LBW_LSEL_W;

  typedef logic [LBW_BYTE_W-1:0] lbw_byte_t;
  typedef logic [LBW_ADDR_W-1:0] lbw_addr_t;
endpackage

// File: rtl/lbw_addr_seq.sv
module lbw_addr_seq
  import lbw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      init,
  input  logic      burst_on,
  output lbw_addr_t addr,
  output logic      done,
  output logic      fire
);
  lbw_addr_t cnt_q;
  logic      done_q;

  assign fire = burst_on & ~init & ~done_q;
  assign addr = cnt_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (init) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (fire) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '1) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lbw_slicer.sv
module lbw_slicer
  import lbw_pkg::*;
#(
  parameter int unsigned N_CELLS = 16,
  localparam int unsigned WORD_W = N_CELLS * LBW_SLICE_W
) (
  input  logic [LBW_N_WORDS*WORD_W-1:0]  words,
  output logic [N_CELLS*LBW_BYTE_W-1:0]  cell_bytes
);
  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    for (genvar j = 0; j < LBW_N_WORDS; j++) begin : g_word
      assign cell_bytes[k*LBW_BYTE_W + j*LBW_SLICE_W +: LBW_SLICE_W] =
        words[j*WORD_W + k*LBW_SLICE_W +: LBW_SLICE_W];
    end
  end
endmodule

// File: rtl/lbw_cell_store.sv
module lbw_cell_store
  import lbw_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [LBW_N_LUTS-1:0]            we,
  input  logic [LBW_BSEL_W-1:0]            waddr,
  input  lbw_byte_t                        wdata,
  input  logic [LBW_N_LUTS*LBW_IDX_W-1:0]  rd_idx,
  output logic [LBW_N_LUTS*LBW_OUT_W-1:0]  rd_out
);
  for (genvar l = 0; l < LBW_N_LUTS; l++) begin : g_lut
    logic [LBW_LUT_BITS-1:0] tbl_q;
    logic [LBW_IDX_W-1:0]    idx;

    always_ff @(posedge clk) begin
      if (!rst_n)     tbl_q <= '0;
      else if (we[l]) tbl_q[waddr*LBW_BYTE_W +: LBW_BYTE_W] <= wdata;
    end

    assign idx = rd_idx[l*LBW_IDX_W +: LBW_IDX_W];
    assign rd_out[l*LBW_OUT_W +: LBW_OUT_W] = tbl_q[idx*LBW_OUT_W +: LBW_OUT_W];
  end
endmodule

// File: rtl/lut_burst_loader.sv
module lut_burst_loader
  import lbw_pkg::*;
#(
  parameter int unsigned N_CELLS = 16,
  localparam int unsigned WORD_W = N_CELLS * LBW_SLICE_W,
  localparam int unsigned CELL_W = $clog2(N_CELLS)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   init,
  input  logic                                   burst_on,
  input  logic [LBW_N_WORDS*WORD_W-1:0]          bus_words,
  input  logic                                   cfg_we,
  input  logic [CELL_W-1:0]                      cfg_cell,
  input  logic [LBW_ADDR_W-1:0]                  cfg_addr,
  input  logic [LBW_BYTE_W-1:0]                  cfg_data,
  input  logic [N_CELLS*LBW_N_LUTS*LBW_IDX_W-1:0] lut_idx,
  output logic [N_CELLS*LBW_N_LUTS*LBW_OUT_W-1:0] lut_out,
  output logic [N_CELLS*LBW_N_LUTS-1:0]          wr_en,
  output logic [LBW_BSEL_W-1:0]                  wr_addr,
  output logic [N_CELLS*LBW_BYTE_W-1:0]          wr_data,
  output logic [LBW_ADDR_W-1:0]                  burst_addr,
  output logic                                   done
);
  lbw_addr_t seq_addr;
  logic      fire;

  lbw_addr_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (init),
    .burst_on (burst_on),
    .addr     (seq_addr),
    .done     (done),
    .fire     (fire)
  );

  lbw_slicer #(.N_CELLS(N_CELLS)) u_slice (
    .words      (bus_words),
    .cell_bytes (wr_data)
  );

  assign burst_addr = seq_addr;
  assign wr_addr    = seq_addr[LBW_BSEL_W-1:0];

  // Table select lives in the upper address bits, byte select below.
  logic [LBW_LSEL_W-1:0] burst_lsel, cfg_lsel;
  assign burst_lsel = seq_addr[LBW_ADDR_W-1 -: LBW_LSEL_W];
  assign cfg_lsel   = cfg_addr[LBW_ADDR_W-1 -: LBW_LSEL_W];

  for (genvar k = 0; k < N_CELLS; k++) begin : g_row
    logic [LBW_N_LUTS-1:0] burst_we, cfg_we_c, cell_we;
    logic [LBW_BSEL_W-1:0] cell_addr;
    lbw_byte_t             cell_data;
    logic                  cfg_hit;

    assign cfg_hit = cfg_we & ~fire & (cfg_cell == CELL_W'(k));

    for (genvar l = 0; l < LBW_N_LUTS; l++) begin : g_sel
      assign burst_we[l] = fire    & (burst_lsel == LBW_LSEL_W'(l));
      assign cfg_we_c[l] = cfg_hit & (cfg_lsel   == LBW_LSEL_W'(l));
    end

    assign cell_we   = burst_we | cfg_we_c;
    assign cell_addr = fire ? seq_addr[LBW_BSEL_W-1:0] : cfg_addr[LBW_BSEL_W-1:0];
    assign cell_data = fire ? wr_data[k*LBW_BYTE_W +: LBW_BYTE_W] : cfg_data;
    assign wr_en[k*LBW_N_LUTS +: LBW_N_LUTS] = burst_we;

    lbw_cell_store u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cell_we),
      .waddr  (cell_addr),
      .wdata  (cell_data),
      .rd_idx (lut_idx[k*LBW_N_LUTS*LBW_IDX_W +: LBW_N_LUTS*LBW_IDX_W]),
      .rd_out (lut_out[k*LBW_N_LUTS*LBW_OUT_W +: LBW_N_LUTS*LBW_OUT_W])
    );
  end
endmodule

// File: rtl/lbw_checker.sv
module lbw_checker
  import lbw_pkg::*;
#(
  parameter int unsigned N_CELLS = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         init,
  input logic                         burst_on,
  input logic [N_CELLS*LBW_N_LUTS-1:0] wr_en,
  input logic [LBW_ADDR_W-1:0]        burst_addr,
  input logic                         done
);
  logic go;
  assign go = burst_on & ~init & ~done;

  // R2: init rewinds the sequencer
  a_r2_init_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (burst_addr == '0) && !done);

  // R2: init blocks any burst write
  a_r2_init_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> (wr_en == '0));

  // R3: a burst write below the last address steps by one
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go && burst_addr != '1) |=> (burst_addr == $past(burst_addr) + 1'b1) && !done);

  // R3: either no table or exactly one table per cell is enabled
  a_r3_one_per_cell: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_en) == 0) || ($countones(wr_en) == N_CELLS));

  // R6: last write raises done and wraps the address
  a_r6_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (go && burst_addr == '1) |=> done && (burst_addr == '0));

  // R7: finished sequencer ignores burst requests
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !init) |=> done && $stable(burst_addr));

  // R8: idle burst request means no enable
  a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_on |-> (wr_en == '0));

  // R10: a paused burst holds its position
  a_r10_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_on && !init) |=> $stable(burst_addr) && $stable(done));
endmodule

bind lut_burst_loader lbw_checker #(.N_CELLS(N_CELLS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init       (init),
  .burst_on   (burst_on),
  .wr_en      (wr_en),
  .burst_addr (burst_addr),
  .done       (done)
);

// File: tb/test_lut_burst_loader.sv
module test_lut_burst_loader;
  localparam int CLK_P = 10;
  localparam int NC    = 16;
  localparam int WW    = 32;
  localparam int WDOG  = 20000;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic           rst_n = 1'b0;
  logic           init = 1'b0, burst_on = 1'b0, cfg_we = 1'b0;
  logic [127:0]   bus_words = '0;
  logic [3:0]     cfg_cell = '0;
  logic [2:0]     cfg_addr = '0;
  logic [7:0]     cfg_data = '0;
  logic [127:0]   lut_idx = '0;
  logic [63:0]    lut_out;
  logic [31:0]    wr_en;
  logic [1:0]     wr_addr;
  logic [127:0]   wr_data;
  logic [2:0]     burst_addr;
  logic           done;

  lut_burst_loader #(.N_CELLS(NC)) i_lut_burst_loader (
    .clk(clk), .rst_n(rst_n), .init(init), .burst_on(burst_on),
    .bus_words(bus_words), .cfg_we(cfg_we), .cfg_cell(cfg_cell),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .lut_idx(lut_idx),
    .lut_out(lut_out), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .burst_addr(burst_addr), .done(done)
  );

  int    checks = 0;
  int    errs   = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // Behavioural row model
  logic [31:0] mem [NC][2];
  int          m_cnt  = 0;
  bit          m_done = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NC; k++)
      for (int l = 0; l < 2; l++) mem[k][l] = '0;
    m_cnt  = 0;
    m_done = 1'b0;
  endtask

  function automatic logic [7:0] burst_byte(input logic [127:0] w, input int k);
    logic [7:0] b;
    for (int j = 0; j < 4; j++) b[j*2 +: 2] = w[j*WW + k*2 +: 2];
    return b;
  endfunction

  task automatic cycle(input bit i_init, input bit i_burst, input logic [127:0] w,
                       input bit c_we, input logic [3:0] c_cell,
                       input logic [2:0] c_addr, input logic [7:0] c_data);
    logic [31:0]  exp_en;
    logic [127:0] exp_data;
    logic [63:0]  exp_out;
    bit           fire;
    @(negedge clk);
    init = i_init; burst_on = i_burst; bus_words = w;
    cfg_we = c_we; cfg_cell = c_cell; cfg_addr = c_addr; cfg_data = c_data;
    lut_idx = {$urandom, $urandom, $urandom, $urandom};
    #1;
    fire   = rst_n && i_burst && !i_init && !m_done;
    exp_en = '0;
    for (int k = 0; k < NC; k++) begin
      if (fire) exp_en[k*2 + m_cnt/4] = 1'b1;
      exp_data[k*8 +: 8] = burst_byte(w, k);
      for (int l = 0; l < 2; l++)
        exp_out[(k*2+l)*2 +: 2] = mem[k][l][lut_idx[(k*2+l)*4 +: 4]*2 +: 2];
    end
    check(cur_req, "wr_en", {96'd0, wr_en}, {96'd0, exp_en});
    check(cur_req, "done/addr", {124'd0, done, burst_addr}, {124'd0, m_done, 3'(m_cnt)});
    check(cur_req, "lut_out", {64'd0, lut_out}, {64'd0, exp_out});
    if (fire) begin
      check("R4", "wr_data", wr_data, exp_data);
      check(cur_req, "wr_addr", {126'd0, wr_addr}, {126'd0, 2'(m_cnt % 4)});
    end
    @(posedge clk);
    if (!rst_n) model_clear();
    else begin
      if (c_we && !fire)
        mem[c_cell][c_addr[2]][c_addr[1:0]*8 +: 8] = c_data;
      if (i_init) begin
        m_cnt = 0; m_done = 1'b0;
      end else if (fire) begin
        for (int k = 0; k < NC; k++)
          mem[k][m_cnt/4][(m_cnt%4)*8 +: 8] = burst_byte(w, k);
        m_cnt++;
        if (m_cnt == 8) begin m_cnt = 0; m_done = 1'b1; end
      end
    end
  endtask

  function automatic logic [127:0] rw();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, rw(), 0, 0, 0, 0);
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) cycle(0, 1, rw(), 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
  endtask

  initial begin
    model_clear();
    cur_req = "R1";
    for (int i = 0; i < 3; i++) cycle(0, 0, '0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    cur_req = "R3";
    cycle(1, 0, '0, 0, 0, 0, 0);
    burst(7);
    cur_req = "R6";
    burst(1);
    idle(1);

    cur_req = "R7";
    burst(5);

    cur_req = "R8";
    idle(4);
    cur_req = "R5";
    idle(12);

    cur_req = "R2";
    cycle(1, 1, rw(), 0, 0, 0, 0);
    burst(3);
    cycle(1, 1, rw(), 0, 0, 0, 0);
    burst(2);

    cur_req = "R10";
    cycle(1, 0, '0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      burst(1);
      idle(i % 3);
    end
    idle(2);

    cur_req = "R9";
    for (int i = 0; i < 10; i++)
      cycle(0, 0, '0, 1, 4'($urandom), 3'($urandom), 8'($urandom));
    cycle(1, 0, '0, 1, 4'd15, 3'd7, 8'hA5);
    for (int i = 0; i < 4; i++)
      cycle(0, 1, rw(), 1, 4'($urandom), 3'($urandom), 8'($urandom));
    idle(3);

    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 16);
      cycle(r == 0, r > 5, rw(), r < 4, 4'($urandom), 3'($urandom), 8'($urandom));
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < WDOG; i++) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule